// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding and Load-Use Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline. It holds the instruction register and the program counter, and it carries a small tag (destination register number, register-write flag) through the execute, memory and write-back pipeline registers. The execute tag also carries a memory-read flag. Each cycle it compares the two source register fields of the decoded instruction with those three tags. From the comparison it produces one 2-bit operand-select code per operand. Each code steers a four-way multiplexer that picks either register-file data or the result of one of the three later stages.

When the instruction in the execute stage is a load and the decoded instruction needs its result straight away, the unit raises a load-use stall. During that stall the program counter and instruction register freeze, and a zeroed control tag enters the execute stage as a bubble. One cycle later the same decoded instruction takes the load value from the memory stage. Register-file data and stage results enter as plain inputs, standing in for the rest of the datapath.

Top module: `fwd_stall_unit`

## Requirements
- R1: Operand select encoding: 0 passes register-file data, 1 passes the execute-stage result, 2 the memory-stage result, 3 the write-back-stage result; each operand output equals the source its select names.
- R2: When several stages match a source register, the nearest wins: execute over memory over write-back.
- R3: A source register number of zero never forwards; its select is 0 even if a stage writes register 0.
- R4: A stage only matches when its register-write flag is set; a matching destination with the flag clear is skipped.
- R5: Operand A is resolved from the Rs field and operand B from the Rt field, each with an independent select.
- R6: The stall output is 1 exactly when the execute-stage memory-read flag is set and at least one select equals 1; a load two or more stages ahead causes no stall.
- R7: The PC-hold, IR-hold and bubble outputs are asserted in the same cycles as the stall output.
- R8: The PC output resets to 0, increments by 1 on each clock edge, and keeps its value on an edge where PC-hold is 1.
- R9: On an edge where IR-hold is 1 the instruction register keeps the decoded instruction, and the fetch inputs of that cycle are discarded.
- R10: On an edge where bubble is 1 the execute-stage tag is loaded with zeros (register-write 0, memory-read 0, destination 0).
- R11: A stall lasts one cycle; in the following cycle the dependent operand selects 2 (memory stage).
- R12: Reset clears the instruction register and all stage tags; otherwise each tag moves one stage further every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchRs | input | REG_W | Fetched instruction first source register |
| fetchRt | input | REG_W | Fetched instruction second source register |
| fetchRd | input | REG_W | Fetched instruction destination register |
| fetchRegWr | input | 1 | Fetched instruction writes a register |
| fetchMemRd | input | 1 | Fetched instruction is a load |
| rfDataA | input | DATA_W | Register-file read data for Rs |
| rfDataB | input | DATA_W | Register-file read data for Rt |
| exResult | input | DATA_W | Result available in the execute stage |
| memResult | input | DATA_W | Result available in the memory stage |
| wbResult | input | DATA_W | Result available in the write-back stage |
| pc | output | PC_W | Program counter |
| fwdSelA | output | 2 | Operand A select code |
| fwdSelB | output | 2 | Operand B select code |
| opndA | output | DATA_W | Selected operand A |
| opndB | output | DATA_W | Selected operand B |
| stall | output | 1 | Load-use hazard detected |
| pcHold | output | 1 | Freeze program counter |
| irHold | output | 1 | Freeze instruction register |
| bubble | output | 1 | Zero the tag entering execute |
| exDest | output | REG_W | Execute-stage destination register |
| exRegWr | output | 1 | Execute-stage register-write flag |
| exMemRd | output | 1 | Execute-stage memory-read flag |

## Verification
The bench builds the unit with DATA_W=16, REG_W=5 and PC_W=8. The narrow PC keeps the expected counter values small enough to list directly beside each step. The narrow data path lets each of the five data inputs carry a distinct pattern, so every operand output shows which source was picked. REG_W=5 keeps the full 32-register space, so register 0 and many non-overlapping destinations can appear in one sequence. Two load-use stalls are placed in the sequence, one on each operand. Both keep different fetch data on the input during the hold cycle, so a broken hold changes the decoded fields and the select codes.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

  // number of source operands resolved per decoded instruction (0 = Rs/A, 1 = Rt/B)
  localparam int NUM_OPND  = 2;
  // number of later stages that can supply a result (0 = execute, 1 = memory, 2 = write-back)
  localparam int NUM_STAGE = 3;

  // operand source code; the value of a stage code is its stage index plus one
  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_EX  = 2'd1,
    SRC_MEM = 2'd2,
    SRC_WB  = 2'd3
  } opSrc_e;

  // strobes from the hazard control to the datapath
  typedef struct packed {
    logic holdPc;
    logic holdIr;
    logic killEx;
  } hazStrobe_t;

endpackage

// File: rtl/fsu_hazard_ctl.sv
module fsu_hazard_ctl
  import fsu_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [NUM_OPND-1:0][REG_W-1:0]  decSrc,
  input  logic [NUM_STAGE-1:0][REG_W-1:0] stgDest,
  input  logic [NUM_STAGE-1:0]            stgRegWr,
  input  logic                            exIsLoad,
  output logic [NUM_OPND-1:0][1:0]        opSel,
  output logic                            loadUse,
  output hazStrobe_t                      strobe
);

  logic [NUM_OPND-1:0] wantsEx;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    logic [NUM_STAGE-1:0] hit;
    logic [1:0]           selG;

    for (genvar s = 0; s < NUM_STAGE; s++) begin : g_stage
      assign hit[s] = (decSrc[g] != '0) && (decSrc[g] == stgDest[s]) && stgRegWr[s];
    end

    // walk from the farthest stage to the nearest so the nearest hit is written last
    always_comb begin
      selG = SRC_RF;
      for (int s = NUM_STAGE - 1; s >= 0; s--) begin
        if (hit[s]) selG = 2'(s + 1);
      end
    end

    assign opSel[g]   = selG;
    assign wantsEx[g] = (selG == SRC_EX);
  end

  assign loadUse       = exIsLoad && (|wantsEx);
  assign strobe.holdPc = loadUse;
  assign strobe.holdIr = loadUse;
  assign strobe.killEx = loadUse;

endmodule

// File: rtl/fsu_datapath.sv
module fsu_datapath
  import fsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int PC_W   = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [REG_W-1:0]                 fetchRs,
  input  logic [REG_W-1:0]                 fetchRt,
  input  logic [REG_W-1:0]                 fetchRd,
  input  logic                             fetchRegWr,
  input  logic                             fetchMemRd,
  input  hazStrobe_t                       strobe,
  input  logic [NUM_OPND-1:0][1:0]         opSel,
  input  logic [NUM_OPND-1:0][DATA_W-1:0]  rfData,
  input  logic [NUM_STAGE-1:0][DATA_W-1:0] stgResult,
  output logic [PC_W-1:0]                  pc,
  output logic [NUM_OPND-1:0][REG_W-1:0]   decSrc,
  output logic [NUM_STAGE-1:0][REG_W-1:0]  stgDest,
  output logic [NUM_STAGE-1:0]             stgRegWr,
  output logic                             exMemRd,
  output logic [NUM_OPND-1:0][DATA_W-1:0]  opnd
);

  // instruction register (decode-stage fields only)
  logic [REG_W-1:0] irRs;
  logic [REG_W-1:0] irRt;
  logic [REG_W-1:0] irRd;
  logic             irRegWr;
  logic             irMemRd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irRs    <= '0;
      irRt    <= '0;
      irRd    <= '0;
      irRegWr <= 1'b0;
      irMemRd <= 1'b0;
    end else if (!strobe.holdIr) begin
      irRs    <= fetchRs;
      irRt    <= fetchRt;
      irRd    <= fetchRd;
      irRegWr <= fetchRegWr;
      irMemRd <= fetchMemRd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (!strobe.holdPc) begin
      pc <= pc + 1'b1;
    end
  end

  assign decSrc[0] = irRs;
  assign decSrc[1] = irRt;

  // stage tags: execute takes the decoded tag or a zero bubble, later stages shift
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stgDest  <= '0;
      stgRegWr <= '0;
      exMemRd  <= 1'b0;
    end else begin
      if (strobe.killEx) begin
        stgDest[0]  <= '0;
        stgRegWr[0] <= 1'b0;
        exMemRd     <= 1'b0;
      end else begin
        stgDest[0]  <= irRd;
        stgRegWr[0] <= irRegWr;
        exMemRd     <= irMemRd;
      end
      for (int s = 1; s < NUM_STAGE; s++) begin
        stgDest[s]  <= stgDest[s-1];
        stgRegWr[s] <= stgRegWr[s-1];
      end
    end
  end

  // operand multiplexers in front of the operand latches
  for (genvar g = 0; g < NUM_OPND; g++) begin : g_mux
    logic [DATA_W-1:0] pick;
    always_comb begin
      case (opSel[g])
        2'd1:    pick = stgResult[0];
        2'd2:    pick = stgResult[1];
        2'd3:    pick = stgResult[2];
        default: pick = rfData[g];
      endcase
    end
    assign opnd[g] = pick;
  end

endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
  import fsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  fetchRs,
  input  logic [REG_W-1:0]  fetchRt,
  input  logic [REG_W-1:0]  fetchRd,
  input  logic              fetchRegWr,
  input  logic              fetchMemRd,
  input  logic [DATA_W-1:0] rfDataA,
  input  logic [DATA_W-1:0] rfDataB,
  input  logic [DATA_W-1:0] exResult,
  input  logic [DATA_W-1:0] memResult,
  input  logic [DATA_W-1:0] wbResult,
  output logic [PC_W-1:0]   pc,
  output logic [1:0]        fwdSelA,
  output logic [1:0]        fwdSelB,
  output logic [DATA_W-1:0] opndA,
  output logic [DATA_W-1:0] opndB,
  output logic              stall,
  output logic              pcHold,
  output logic              irHold,
  output logic              bubble,
  output logic [REG_W-1:0]  exDest,
  output logic              exRegWr,
  output logic              exMemRd
);

  hazStrobe_t                       strobe;
  logic [NUM_OPND-1:0][1:0]         opSel;
  logic [NUM_OPND-1:0][REG_W-1:0]   decSrc;
  logic [NUM_STAGE-1:0][REG_W-1:0]  stgDest;
  logic [NUM_STAGE-1:0]             stgRegWr;
  logic [NUM_OPND-1:0][DATA_W-1:0]  rfData;
  logic [NUM_STAGE-1:0][DATA_W-1:0] stgResult;
  logic [NUM_OPND-1:0][DATA_W-1:0]  opnd;
  logic                             loadUse;

  assign rfData    = {rfDataB, rfDataA};
  assign stgResult = {wbResult, memResult, exResult};

  fsu_hazard_ctl #(
    .REG_W (REG_W)
  ) u_ctl (
    .decSrc   (decSrc),
    .stgDest  (stgDest),
    .stgRegWr (stgRegWr),
    .exIsLoad (exMemRd),
    .opSel    (opSel),
    .loadUse  (loadUse),
    .strobe   (strobe)
  );

  fsu_datapath #(
    .DATA_W (DATA_W),
    .REG_W  (REG_W),
    .PC_W   (PC_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetchRs    (fetchRs),
    .fetchRt    (fetchRt),
    .fetchRd    (fetchRd),
    .fetchRegWr (fetchRegWr),
    .fetchMemRd (fetchMemRd),
    .strobe     (strobe),
    .opSel      (opSel),
    .rfData     (rfData),
    .stgResult  (stgResult),
    .pc         (pc),
    .decSrc     (decSrc),
    .stgDest    (stgDest),
    .stgRegWr   (stgRegWr),
    .exMemRd    (exMemRd),
    .opnd       (opnd)
  );

  assign fwdSelA = opSel[0];
  assign fwdSelB = opSel[1];
  assign opndA   = opnd[0];
  assign opndB   = opnd[1];
  assign stall   = loadUse;
  assign pcHold  = strobe.holdPc;
  assign irHold  = strobe.holdIr;
  assign bubble  = strobe.killEx;
  assign exDest  = stgDest[0];
  assign exRegWr = stgRegWr[0];

endmodule

// File: rtl/fsu_checker.sv
module fsu_checker #(
  parameter int REG_W = 5,
  parameter int PC_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PC_W-1:0]  pc,
  input logic             pcHold,
  input logic             irHold,
  input logic             stall,
  input logic             bubble,
  input logic [1:0]       fwdSelA,
  input logic [1:0]       fwdSelB,
  input logic [REG_W-1:0] decRs,
  input logic [REG_W-1:0] decRt,
  input logic [REG_W-1:0] exDest,
  input logic [REG_W-1:0] memDest,
  input logic             exRegWr,
  input logic             exMemRd
);

  p_zero_src_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (decRs == '0) |-> (fwdSelA == 2'd0));

  p_zero_src_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (decRt == '0) |-> (fwdSelB == 2'd0));

  p_ex_match_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwdSelA == 2'd1) |-> (exRegWr && (exDest == decRs)));

  p_ex_match_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fwdSelB == 2'd1) |-> (exRegWr && (exDest == decRt)));

  p_stall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (exMemRd && ((fwdSelA == 2'd1) || (fwdSelB == 2'd1))));

  p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pcHold |=> (pc == $past(pc)));

  p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pcHold |=> (pc == PC_W'($past(pc) + 1'b1)));

  p_ir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irHold |=> ($stable(decRs) && $stable(decRt)));

  p_bubble_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (!exRegWr && !exMemRd));

  p_single_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  p_tag_shift_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (memDest == $past(exDest)));

endmodule

bind fwd_stall_unit fsu_checker #(
  .REG_W (REG_W),
  .PC_W  (PC_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pc      (pc),
  .pcHold  (pcHold),
  .irHold  (irHold),
  .stall   (stall),
  .bubble  (bubble),
  .fwdSelA (fwdSelA),
  .fwdSelB (fwdSelB),
  .decRs   (decSrc[0]),
  .decRt   (decSrc[1]),
  .exDest  (exDest),
  .memDest (stgDest[1]),
  .exRegWr (exRegWr),
  .exMemRd (exMemRd)
);

// File: tb/fwd_stall_unit_tb.sv
`timescale 1ns/1ps
module fwd_stall_unit_tb;

  localparam int DATA_W = 16;
  localparam int REG_W  = 5;
  localparam int PC_W   = 8;
  localparam int NROW   = 26;

  localparam logic [DATA_W-1:0] RF_A = 16'h1111;
  localparam logic [DATA_W-1:0] RF_B = 16'h2222;
  localparam logic [DATA_W-1:0] EX_V = 16'h3333;
  localparam logic [DATA_W-1:0] ME_V = 16'h4444;
  localparam logic [DATA_W-1:0] WB_V = 16'h5555;

  typedef struct packed {
    logic [4:0] rs;
    logic [4:0] rt;
    logic [4:0] rd;
    logic       w;
    logic       m;
    logic [1:0] sa;
    logic [1:0] sb;
    logic       st;
    logic [7:0] pcx;
    logic       bub;
  } row_t;

  // fetched instruction, then expected decode-stage results after the next edge
  localparam row_t TBL [NROW] = '{
    '{5'd1,  5'd2,  5'd3,  1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 8'd1,  1'b0}, // R1 plain reads
    '{5'd3,  5'd4,  5'd5,  1'b1, 1'b0, 2'd1, 2'd0, 1'b0, 8'd2,  1'b0}, // R1 back-to-back ALU
    '{5'd3,  5'd5,  5'd6,  1'b1, 1'b0, 2'd2, 2'd1, 1'b0, 8'd3,  1'b0}, // R5 independent selects
    '{5'd3,  5'd5,  5'd7,  1'b1, 1'b0, 2'd3, 2'd2, 1'b0, 8'd4,  1'b0}, // R1 write-back source
    '{5'd3,  5'd6,  5'd3,  1'b1, 1'b0, 2'd0, 2'd2, 1'b0, 8'd5,  1'b0},
    '{5'd3,  5'd3,  5'd8,  1'b1, 1'b0, 2'd1, 2'd1, 1'b0, 8'd6,  1'b0},
    '{5'd3,  5'd7,  5'd9,  1'b1, 1'b0, 2'd2, 2'd3, 1'b0, 8'd7,  1'b0},
    '{5'd8,  5'd3,  5'd3,  1'b1, 1'b0, 2'd2, 2'd3, 1'b0, 8'd8,  1'b0},
    '{5'd3,  5'd9,  5'd3,  1'b1, 1'b0, 2'd1, 2'd2, 1'b0, 8'd9,  1'b0},
    '{5'd3,  5'd9,  5'd0,  1'b1, 1'b0, 2'd1, 2'd3, 1'b0, 8'd10, 1'b0}, // R2 execute beats memory
    '{5'd0,  5'd3,  5'd11, 1'b1, 1'b0, 2'd0, 2'd2, 1'b0, 8'd11, 1'b0}, // R3 r0 in execute; R2 memory beats write-back
    '{5'd11, 5'd3,  5'd12, 1'b0, 1'b0, 2'd1, 2'd3, 1'b0, 8'd12, 1'b0},
    '{5'd12, 5'd11, 5'd13, 1'b1, 1'b0, 2'd0, 2'd2, 1'b0, 8'd13, 1'b0}, // R4 non-writer skipped
    '{5'd13, 5'd0,  5'd14, 1'b1, 1'b1, 2'd1, 2'd0, 1'b0, 8'd14, 1'b0}, // R6 no stall, execute not a load
    '{5'd14, 5'd13, 5'd15, 1'b1, 1'b0, 2'd1, 2'd2, 1'b1, 8'd15, 1'b0}, // R6 load-use on A
    '{5'd20, 5'd21, 5'd22, 1'b1, 1'b0, 2'd2, 2'd3, 1'b0, 8'd15, 1'b1}, // R9 fetch discarded, R11, R10
    '{5'd15, 5'd0,  5'd16, 1'b1, 1'b0, 2'd1, 2'd0, 1'b0, 8'd16, 1'b0},
    '{5'd16, 5'd0,  5'd17, 1'b1, 1'b1, 2'd1, 2'd0, 1'b0, 8'd17, 1'b0},
    '{5'd5,  5'd18, 5'd19, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 8'd18, 1'b0}, // R6 load in execute, no match
    '{5'd17, 5'd19, 5'd20, 1'b1, 1'b0, 2'd2, 2'd1, 1'b0, 8'd19, 1'b0}, // R6 load two ahead, no stall
    '{5'd0,  5'd0,  5'd21, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 8'd20, 1'b0},
    '{5'd2,  5'd21, 5'd22, 1'b1, 1'b0, 2'd0, 2'd1, 1'b1, 8'd21, 1'b0}, // R6 load-use on B
    '{5'd21, 5'd21, 5'd23, 1'b1, 1'b1, 2'd0, 2'd2, 1'b0, 8'd21, 1'b1}, // R9, R11, R10
    '{5'd0,  5'd0,  5'd0,  1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 8'd22, 1'b0},
    '{5'd0,  5'd0,  5'd25, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 8'd23, 1'b0}, // R3 load to r0 never forwards
    '{5'd0,  5'd0,  5'd0,  1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 8'd24, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [REG_W-1:0]  fetchRs = '0;
  logic [REG_W-1:0]  fetchRt = '0;
  logic [REG_W-1:0]  fetchRd = '0;
  logic              fetchRegWr = 1'b0;
  logic              fetchMemRd = 1'b0;
  logic [PC_W-1:0]   pc;
  logic [1:0]        fwdSelA;
  logic [1:0]        fwdSelB;
  logic [DATA_W-1:0] opndA;
  logic [DATA_W-1:0] opndB;
  logic              stall;
  logic              pcHold;
  logic              irHold;
  logic              bubble;
  logic [REG_W-1:0]  exDest;
  logic              exRegWr;
  logic              exMemRd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fwd_stall_unit #(
    .DATA_W (DATA_W),
    .REG_W  (REG_W),
    .PC_W   (PC_W)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetchRs    (fetchRs),
    .fetchRt    (fetchRt),
    .fetchRd    (fetchRd),
    .fetchRegWr (fetchRegWr),
    .fetchMemRd (fetchMemRd),
    .rfDataA    (RF_A),
    .rfDataB    (RF_B),
    .exResult   (EX_V),
    .memResult  (ME_V),
    .wbResult   (WB_V),
    .pc         (pc),
    .fwdSelA    (fwdSelA),
    .fwdSelB    (fwdSelB),
    .opndA      (opndA),
    .opndB      (opndB),
    .stall      (stall),
    .pcHold     (pcHold),
    .irHold     (irHold),
    .bubble     (bubble),
    .exDest     (exDest),
    .exRegWr    (exRegWr),
    .exMemRd    (exMemRd)
  );

  function automatic logic [DATA_W-1:0] srcVal(input logic [1:0] sel, input logic [DATA_W-1:0] rf);
    case (sel)
      2'd1:    return EX_V;
      2'd2:    return ME_V;
      2'd3:    return WB_V;
      default: return rf;
    endcase
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkCleared(input string when);
    chk({"R8 pc ", when}, pc, 0);
    chk({"R12 exDest ", when}, exDest, 0);
    chk({"R12 exRegWr ", when}, exRegWr, 0);
    chk({"R12 exMemRd ", when}, exMemRd, 0);
    chk({"R1 fwdSelA ", when}, fwdSelA, 0);
    chk({"R1 fwdSelB ", when}, fwdSelB, 0);
    chk({"R6 stall ", when}, stall, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkCleared("in reset");
    rst_n = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      fetchRs    = TBL[i].rs;
      fetchRt    = TBL[i].rt;
      fetchRd    = TBL[i].rd;
      fetchRegWr = TBL[i].w;
      fetchMemRd = TBL[i].m;
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2 fwdSelA row %0d", i + 1), fwdSelA, TBL[i].sa);
      chk($sformatf("R5 fwdSelB row %0d", i + 1), fwdSelB, TBL[i].sb);
      chk($sformatf("R1 opndA row %0d", i + 1), opndA, srcVal(TBL[i].sa, RF_A));
      chk($sformatf("R1 opndB row %0d", i + 1), opndB, srcVal(TBL[i].sb, RF_B));
      chk($sformatf("R6 stall row %0d", i + 1), stall, TBL[i].st);
      chk($sformatf("R7 strobes row %0d", i + 1), {pcHold, irHold, bubble},
          {3{TBL[i].st}});
      chk($sformatf("R8 pc row %0d", i + 1), pc, TBL[i].pcx);
      if (TBL[i].bub)
        chk($sformatf("R10 bubble tag row %0d", i + 1), {exDest, exRegWr, exMemRd}, 0);
    end
    // after the last row the execute stage holds the destination 25 writer
    chk("R12 exDest after table", exDest, 25);
    chk("R12 exRegWr after table", exRegWr, 1);

    // reset in the middle of activity clears everything
    fetchRs    = 5'd7;
    fetchRt    = 5'd7;
    fetchRd    = 5'd7;
    fetchRegWr = 1'b1;
    fetchMemRd = 1'b1;
    rst_n      = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checkCleared("mid-run reset");
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R8 pc first step", pc, 1);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 5000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule